// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters handed over by a host into asynchronous serial frames on a single output line. The host writes a character of up to nine bits into a one-entry holding buffer. When the line is free and transmission is enabled, the character moves into the shift stage. The shift stage sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The buffer empties as soon as the shift stage takes the character, so the host can queue the next character while the current one is still being sent. Frames then follow each other with no idle gap.

The frame layout is chosen at run time by a character-size code, a parity code and a stop-bit select. The bit rate comes from a 12-bit divisor: a prescaler produces one tick every divisor+1 clocks, and sixteen ticks make one bit time. The framing controls and the divisor are captured when a frame starts and stay fixed until that frame ends. There are two flags. The buffer-empty flag reports room for a new character. The transmit-complete flag reports that the line has gone quiet with nothing left to send. Each flag has its own enable and drives its own interrupt request.

Top module: `sertx_core`

## Requirements
- R1: After reset the serial line is high, the buffer-empty flag is 1, the transmit-complete flag is 0 and both interrupt requests are 0. The line is high whenever no frame is in progress.
- R2: A frame is a start bit at 0, then the data bits least significant first, then the optional parity bit, then the stop bits at 1.
- R3: The character-size code selects the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The unassigned codes 100, 101 and 110 give 8. Data bits above the selected size are not sent.
- R4: Parity code 00 or 01 sends no parity bit. Code 10 sends even parity, so the count of ones over the data and parity bits is even. Code 11 sends odd parity, so that count is odd.
- R5: Stop select 0 sends one stop bit and stop select 1 sends two.
- R6: Every bit lasts 16*(divisor+1) clocks. The start bit begins one clock after the write that fills an empty buffer while the line is idle and transmission is enabled. The transmit-complete flag rises exactly frame_length*16*(divisor+1) clocks after the start bit begins.
- R7: A write accepted while the buffer is empty clears the buffer-empty flag. The flag returns to 1 in the clock after the shift stage takes the character. A character already in the buffer when a frame ends starts its own start bit in the very next bit slot, with no idle time.
- R8: The transmit-complete flag is set at the end of the last stop bit only if the buffer is empty. It is cleared by a clear strobe or by an accepted write, and the write takes priority over a frame ending in the same clock.
- R9: A write while the buffer is full is ignored: the character already held is the one sent, and the ignored character is never sent.
- R10: With the transmit enable at 0, no new frame starts and the line stays high. A frame already in progress is sent to its end.
- R11: The empty interrupt request is 1 only when both the buffer-empty flag and its enable are 1. The complete interrupt request is 1 only when both the transmit-complete flag and its enable are 1.
- R12: The framing controls and the divisor are captured when a frame starts. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| size_code | input | 3 | Character-size code |
| par_mode | input | 2 | Parity code |
| two_stop | input | 1 | Stop-bit select |
| divisor | input | 12 | Baud divisor |
| wr_stb | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | 9 | Character to write |
| done_clr | input | 1 | Clears the transmit-complete flag |
| ie_empty | input | 1 | Enable for the empty interrupt request |
| ie_done | input | 1 | Enable for the complete interrupt request |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding buffer can accept a character |
| done_flag | output | 1 | Transmit complete |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |

## Verification
Seven table vectors cover every character size, including one unassigned code, under each parity code, both stop selects and three divisors. Each frame is sampled in the middle of every bit, so a wrong bit order, parity sense, frame length or bit period each gives a different mismatch pattern. The exact clock on which the transmit-complete flag rises pins the bit time to a single clock. Directed sequences cover a second write while the buffer is full, transmit disable before and during a frame, and two queued characters that must run with no gap. They also cover the two ways of clearing the complete flag, the interrupt enables, and a change of the framing controls in the middle of a frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_t;

   // number of data bits for a size code; unassigned codes fall back to 8
   function automatic logic [3:0] char_bits(input logic [2:0] code);
      case (code)
         3'b000:  char_bits = 4'd5;
         3'b001:  char_bits = 4'd6;
         3'b010:  char_bits = 4'd7;
         3'b111:  char_bits = 4'd9;
         default: char_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 12,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             bit_end
);
   localparam int SUB_W = $clog2(OVS);

   if (OVS < 2) begin : g_bad_ovs
      $error("sertx_baud: OVS must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("sertx_baud: DIV_W must be positive");
   end

   logic [DIV_W-1:0] pre_q;
   logic [SUB_W-1:0] sub_q;
   logic             tick;

   assign tick    = (pre_q == divisor);
   assign bit_end = run & tick & (sub_q == SUB_W'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         sub_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         sub_q <= '0;
      end else if (tick) begin
         pre_q <= '0;
         sub_q <= (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              frame_end,
   input  logic              done_clr,
   input  logic              ie_empty,
   input  logic              ie_done,
   output logic              buf_full,
   output logic [DATA_W-1:0] buf_data,
   output logic              empty_flag,
   output logic              done_flag,
   output logic              irq_empty,
   output logic              irq_done
);
   logic accept;
   logic done_q;

   assign accept     = wr_stb & ~buf_full;
   assign empty_flag = ~buf_full;
   assign done_flag  = done_q;
   assign irq_empty  = empty_flag & ie_empty;
   assign irq_done   = done_q & ie_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_data <= '0;
         done_q   <= 1'b0;
      end else begin
         if (accept) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
         end else if (take) begin
            buf_full <= 1'b0;
         end
         if (accept)         done_q <= 1'b0;
         else if (frame_end) done_q <= 1'b1;
         else if (done_clr)  done_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int DIV_W     = 12,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_data,
   input  logic [2:0]        size_code,
   input  logic [1:0]        par_mode,
   input  logic              two_stop,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              bit_end,
   output logic              take,
   output logic              frame_end,
   output logic              busy,
   output logic              txd,
   output logic [DIV_W-1:0]  div_q
);
   if (DATA_W < 9) begin : g_bad_width
      $error("sertx_shifter: DATA_W must hold a 9-bit character");
   end

   tx_state_t         state_q;
   logic [DATA_W-1:0] sh_q;
   logic [3:0]        cnt_q;
   logic              par_q, par_on_q, two_q, stop_more_q;
   logic              start_ok, par_on_w, last_slot;
   logic [3:0]        nbits;
   logic [DATA_W-1:0] masked;

   if (PARITY_EN) begin : g_par
      assign par_on_w = par_mode[1];
   end else begin : g_nopar
      assign par_on_w = 1'b0;
   end

   assign nbits     = char_bits(size_code);
   assign masked    = buf_data & ~({DATA_W{1'b1}} << nbits);
   assign start_ok  = buf_full & tx_en;
   assign last_slot = (state_q == ST_STOP) & bit_end & ~stop_more_q;
   assign take      = start_ok & ((state_q == ST_IDLE) | last_slot);
   assign frame_end = last_slot & ~buf_full;
   assign busy      = (state_q != ST_IDLE);

   always_comb begin
      case (state_q)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = sh_q[0];
         ST_PAR:   txd = par_q;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sh_q        <= '0;
         cnt_q       <= '0;
         par_q       <= 1'b0;
         par_on_q    <= 1'b0;
         two_q       <= 1'b0;
         stop_more_q <= 1'b0;
         div_q       <= '0;
      end else if (take) begin
         state_q     <= ST_START;
         sh_q        <= masked;
         cnt_q       <= nbits;
         par_q       <= (^masked) ^ par_mode[0];
         par_on_q    <= par_on_w;
         two_q       <= two_stop;
         stop_more_q <= 1'b0;
         div_q       <= divisor;
      end else begin
         case (state_q)
            ST_START: if (bit_end) state_q <= ST_DATA;
            ST_DATA: if (bit_end) begin
               sh_q  <= sh_q >> 1;
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == 4'd1) begin
                  if (par_on_q) begin
                     state_q <= ST_PAR;
                  end else begin
                     state_q     <= ST_STOP;
                     stop_more_q <= two_q;
                  end
               end
            end
            ST_PAR: if (bit_end) begin
               state_q     <= ST_STOP;
               stop_more_q <= two_q;
            end
            ST_STOP: if (bit_end) begin
               if (stop_more_q) stop_more_q <= 1'b0;
               else             state_q     <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
   parameter int DATA_W    = 9,
   parameter int DIV_W     = 12,
   parameter int OVS       = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [2:0]        size_code,
   input  logic [1:0]        par_mode,
   input  logic              two_stop,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done_clr,
   input  logic              ie_empty,
   input  logic              ie_done,
   output logic              txd,
   output logic              empty_flag,
   output logic              done_flag,
   output logic              irq_empty,
   output logic              irq_done
);
   logic              buf_full, take, frame_end, busy, bit_end;
   logic [DATA_W-1:0] buf_data;
   logic [DIV_W-1:0]  div_q;

   sertx_hold #(.DATA_W(DATA_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .take(take), .frame_end(frame_end), .done_clr(done_clr),
      .ie_empty(ie_empty), .ie_done(ie_done), .buf_full(buf_full),
      .buf_data(buf_data), .empty_flag(empty_flag), .done_flag(done_flag),
      .irq_empty(irq_empty), .irq_done(irq_done)
   );

   sertx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PARITY_EN(PARITY_EN)) i_shift (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .buf_full(buf_full),
      .buf_data(buf_data), .size_code(size_code), .par_mode(par_mode),
      .two_stop(two_stop), .divisor(divisor), .bit_end(bit_end),
      .take(take), .frame_end(frame_end), .busy(busy), .txd(txd),
      .div_q(div_q)
   );

   sertx_baud #(.DIV_W(DIV_W), .OVS(OVS)) i_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .divisor(div_q),
      .bit_end(bit_end)
   );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              wr_stb,
   input logic              txd,
   input logic              empty_flag,
   input logic              done_flag,
   input logic              busy,
   input logic [DATA_W-1:0] buf_data
);
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);                                       // R1
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);                                // R2
   AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && empty_flag) |=> !empty_flag);              // R7
   AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag |-> empty_flag);                            // R8
   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !empty_flag) |=> $stable(buf_data));       // R9
   AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !busy) |=> !busy);                         // R10
endmodule

bind sertx_core sertx_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .txd(txd),
   .empty_flag(empty_flag), .done_flag(done_flag), .busy(busy),
   .buf_data(buf_data)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b1;
   logic [2:0]  size_code = 3'b011;
   logic [1:0]  par_mode = 2'b00;
   logic        two_stop = 1'b0;
   logic [11:0] divisor = 12'd0;
   logic        wr_stb = 1'b0;
   logic [8:0]  wr_data = '0;
   logic        done_clr = 1'b0;
   logic        ie_empty = 1'b0;
   logic        ie_done = 1'b0;
   logic        txd, empty_flag, done_flag, irq_empty, irq_done;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   sertx_core i_sertx_core (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .size_code(size_code),
      .par_mode(par_mode), .two_stop(two_stop), .divisor(divisor),
      .wr_stb(wr_stb), .wr_data(wr_data), .done_clr(done_clr),
      .ie_empty(ie_empty), .ie_done(ie_done), .txd(txd),
      .empty_flag(empty_flag), .done_flag(done_flag),
      .irq_empty(irq_empty), .irq_done(irq_done)
   );

   // code, parity, stop, divisor, data
   localparam logic [26:0] VECS [0:6] = '{
      {3'b011, 2'b00, 1'b0, 12'd0, 9'h041},
      {3'b000, 2'b10, 1'b0, 12'd0, 9'h0B5},
      {3'b001, 2'b11, 1'b1, 12'd1, 9'h02C},
      {3'b010, 2'b10, 1'b1, 12'd0, 9'h07F},
      {3'b111, 2'b11, 1'b0, 12'd0, 9'h1A5},
      {3'b111, 2'b00, 1'b1, 12'd2, 9'h100},
      {3'b101, 2'b01, 1'b0, 12'd0, 9'h1C3}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= 150000) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: act=%0d exp<%0d cycles", cycles, 150000);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int size_of(input logic [2:0] c);
      case (c)
         3'b000: return 5;
         3'b001: return 6;
         3'b010: return 7;
         3'b111: return 9;
         default: return 8;
      endcase
   endfunction

   // expected frame, bit 0 first on the line, unused positions 1
   function automatic logic [12:0] exp_frame(input logic [2:0] c, input logic [1:0] p,
                                             input logic s, input logic [8:0] d);
      logic [12:0] f;
      int n, k;
      logic pb;
      f = '1;
      n = size_of(c);
      f[0] = 1'b0;
      pb = p[0];
      for (int i = 0; i < n; i++) begin
         f[1+i] = d[i];
         pb = pb ^ d[i];
      end
      k = 1 + n;
      if (p[1]) f[k] = pb;
      return f;
   endfunction

   function automatic int exp_len(input logic [2:0] c, input logic [1:0] p, input logic s);
      return 2 + size_of(c) + int'(p[1]) + int'(s);
   endfunction

   task automatic write(input logic [8:0] d);
      @(negedge clk);
      wr_stb = 1'b1;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic wait_start();
      @(negedge txd);
   endtask

   // called right after the start edge; samples every bit at its middle
   task automatic grab(input int len, input int bt, output logic [12:0] f);
      f = '1;
      repeat (bt / 2) @(posedge clk);
      @(negedge clk);
      f[0] = txd;
      for (int i = 1; i < len; i++) begin
         repeat (bt) @(posedge clk);
         @(negedge clk);
         f[i] = txd;
      end
   endtask

   initial begin
      logic [12:0] got, want;
      int bt, len;
      logic lowseen;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd after reset", txd, 1);
      chk(empty_flag == 1'b1, "R1 empty after reset", empty_flag, 1);
      chk(done_flag == 1'b0, "R1 done after reset", done_flag, 0);
      chk(irq_empty == 1'b0 && irq_done == 1'b0, "R1 irqs after reset", {irq_empty, irq_done}, 0);

      // table: R2 R3 R4 R5 R6 R8
      for (int v = 0; v < 7; v++) begin
         size_code = VECS[v][26:24];
         par_mode  = VECS[v][23:22];
         two_stop  = VECS[v][21];
         divisor   = VECS[v][20:9];
         bt  = 16 * (int'(VECS[v][20:9]) + 1);
         len = exp_len(VECS[v][26:24], VECS[v][23:22], VECS[v][21]);
         want = exp_frame(VECS[v][26:24], VECS[v][23:22], VECS[v][21], VECS[v][8:0]);
         write(VECS[v][8:0]);
         wait_start();
         grab(len, bt, got);
         chk(got == want, $sformatf("R2/R3/R4/R5 frame vec %0d", v), got, want);
         repeat (bt / 2 - 1) @(posedge clk);
         @(negedge clk);
         chk(done_flag == 1'b0, $sformatf("R6 done early vec %0d", v), done_flag, 0);
         @(posedge clk);
         @(negedge clk);
         chk(done_flag == 1'b1, $sformatf("R6/R8 done on time vec %0d", v), done_flag, 1);
      end

      // R11 interrupt enables
      ie_empty = 1'b1; ie_done = 1'b1;
      @(negedge clk);
      chk(irq_empty == 1'b1, "R11 irq_empty enabled", irq_empty, 1);
      chk(irq_done == 1'b1, "R11 irq_done enabled", irq_done, 1);
      ie_empty = 1'b0; ie_done = 1'b0;
      @(negedge clk);
      chk(irq_empty == 1'b0 && irq_done == 1'b0, "R11 irqs masked", {irq_empty, irq_done}, 0);

      // R8 clear strobe
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk(done_flag == 1'b0, "R8 clear strobe", done_flag, 0);

      // R9 R10: disabled, fill, second write ignored
      size_code = 3'b011; par_mode = 2'b00; two_stop = 1'b0; divisor = 12'd0;
      tx_en = 1'b0;
      write(9'h0F3);
      lowseen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!txd) lowseen = 1'b1;
      end
      chk(lowseen == 1'b0, "R10 line idle while disabled", lowseen, 0);
      chk(empty_flag == 1'b0, "R7 full after write", empty_flag, 0);
      write(9'h055);
      chk(empty_flag == 1'b0, "R9 still full", empty_flag, 0);
      tx_en = 1'b1;
      wait_start();
      @(negedge clk);
      tx_en = 1'b0;
      grab(10, 16, got);
      want = exp_frame(3'b011, 2'b00, 1'b0, 9'h0F3);
      chk(got == want, "R9/R10 held char sent in full", got, want);
      repeat (16) @(posedge clk);
      @(negedge clk);
      chk(done_flag == 1'b1 && empty_flag == 1'b1, "R8 done after disabled frame", {done_flag, empty_flag}, 3);
      tx_en = 1'b1;
      lowseen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!txd) lowseen = 1'b1;
      end
      chk(lowseen == 1'b0, "R9 ignored char never sent", lowseen, 0);

      // R8 write clears done
      tx_en = 1'b0;
      write(9'h0C6);
      chk(done_flag == 1'b0, "R8 write clears done", done_flag, 1'b0);
      tx_en = 1'b1;
      wait_start();
      grab(10, 16, got);
      want = exp_frame(3'b011, 2'b00, 1'b0, 9'h0C6);
      chk(got == want, "R2 frame after enable", got, want);
      repeat (16) @(posedge clk);

      // R7 back-to-back
      write(9'h03A);
      fork
         begin
            wait_start();
            grab(10, 16, got);
         end
         begin
            @(posedge clk);
            @(negedge clk);
            chk(empty_flag == 1'b1, "R7 empty after load", empty_flag, 1);
            write(9'h1E1);
         end
      join
      want = exp_frame(3'b011, 2'b00, 1'b0, 9'h03A);
      chk(got == want, "R7 first queued frame", got, want);
      chk(empty_flag == 1'b0, "R7 second char waiting", empty_flag, 0);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b0, "R7 no gap between frames", txd, 0);
      chk(done_flag == 1'b0, "R8 no done with char pending", done_flag, 0);
      grab(10, 16, got);
      want = exp_frame(3'b011, 2'b00, 1'b0, 9'h1E1);
      chk(got == want, "R7 second queued frame", got, want);
      repeat (16) @(posedge clk);

      // R12 controls latched at frame start
      write(9'h0A5);
      wait_start();
      @(negedge clk);
      size_code = 3'b000; par_mode = 2'b11; two_stop = 1'b1; divisor = 12'd5;
      grab(10, 16, got);
      want = exp_frame(3'b011, 2'b00, 1'b0, 9'h0A5);
      chk(got == want, "R12 mid-frame change ignored", got, want);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(done_flag == 1'b1, "R12 frame length kept", done_flag, 1);

      summary();
   end
endmodule